// File: doc/BRIEF.md
# Opcode/Data Microprocessor Bus Port

This block is the slave side of an 8-bit asynchronous processor bus. The processor drives active-low chip select, read and write strobes, and a control/data line. The strobes are synchronized into the block clock, and their edges are detected there. A write is taken when the write strobe rises. The control/data line then decides whether the byte goes to the opcode register or to the operand register. Each register gives a one-cycle pulse when it is loaded.

A read is taken when the read strobe falls. The byte returned depends on the control/data line and on the last opcode written. It is either the low eight overflow flags of a ten-channel status field, the remaining two flags padded with zeros, or a general status byte.

The block also drives the enable for the tri-state data bus. After a synchronous reset, the block waits a fixed number of frame pulses before it accepts any bus cycle or drives the bus.

Top module: `cpu_bus_port`

## Requirements
- R1: A write strobe rise with chip select low and control/data high loads the bus byte into `opcode` and pulses `opcode_stb` for exactly one cycle.
- R2: A write strobe rise with chip select low and control/data low loads the bus byte into `operand` and pulses `operand_stb` for exactly one cycle. Data writes never change `opcode`.
- R3: Outside status mode, a read with control/data low returns `ovf_flags[7:0]` on `bus_out`.
- R4: Outside status mode, a read with control/data high returns `ovf_flags[9]` on bit 1 and `ovf_flags[8]` on bit 0, with bits 7..2 zero.
- R5: Writing opcode value `STATUS_OP` (default 8'h06) enters status mode. In status mode every read returns `gen_status`, whatever the control/data line says. Operand writes do not end status mode. Writing any other opcode ends it.
- R6: `bus_oe` is low in any cycle after chip select was high. While chip select and the read strobe are low, and after initialization, `bus_oe` goes high.
- R7: A synchronous reset clears `opcode`, `operand`, `bus_out` and status mode. After reset, the block ignores all strobes and keeps `bus_oe` low until `INIT_FRAMES` (default 2) `frame_sync` pulses have been seen.
- R8: Strobes that occur while chip select is high leave `opcode`, `operand`, `bus_out` and both strobe pulses unchanged.
- R9: `bus_out` changes only in the cycle after a detected read strobe fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | One-cycle frame pulse, counted during initialization |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe, asynchronous |
| wr_n | input | 1 | Active-low write strobe, asynchronous |
| cd | input | 1 | Control/data select: opcode vs operand on writes, status half on reads |
| bus_in | input | 8 | Byte from the processor data bus |
| bus_out | output | 8 | Byte returned to the processor |
| bus_oe | output | 1 | Tri-state enable for the data bus |
| ovf_flags | input | 10 | Per-channel overflow flags |
| gen_status | input | 8 | General status byte |
| opcode | output | 8 | Last opcode written |
| opcode_stb | output | 1 | One-cycle pulse when `opcode` is loaded |
| operand | output | 8 | Last operand written |
| operand_stb | output | 1 | One-cycle pulse when `operand` is loaded |

## Verification
The hardest state to reach is status mode after it has already been disturbed. The stimulus enters the mode, then runs operand writes and reads on both control/data levels inside it. It then leaves the mode with a neighbouring opcode and finally applies a reset in the middle of the mode. Reaching the blocked window after reset takes a further step: the frame pulse generator is held off, so bus cycles land before initialization ends. Strobes with chip select high are replayed after a known read, so any leak would show as a change on `bus_out`.

// File: rtl/cbp_pkg.sv
package cbp_pkg;
  typedef enum logic [1:0] {
    SEL_OVF_LO = 2'd0,
    SEL_OVF_HI = 2'd1,
    SEL_GEN    = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/strobe_edge.sv
// Synchronizes an asynchronous active-low strobe and flags one edge.
module strobe_edge #(
  parameter int STAGES = 2,
  parameter bit RISE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic level,
  output logic evt
);
  logic [STAGES:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '1;
    else     sr <= {sr[STAGES-1:0], strobe_n};
  end

  assign level = sr[STAGES-1];

  generate
    if (RISE) begin : g_rise
      assign evt = sr[STAGES-1] & ~sr[STAGES];
    end else begin : g_fall
      assign evt = ~sr[STAGES-1] & sr[STAGES];
    end
  endgenerate
endmodule

// File: rtl/init_gate.sv
// Holds the port closed until a number of frame pulses follow reset.
module init_gate #(
  parameter int FRAMES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_sync,
  output logic ready
);
  localparam int CW = $clog2(FRAMES + 1);
  localparam logic [CW-1:0] LAST = CW'(FRAMES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                           cnt <= '0;
    else if (frame_sync && cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign ready = (cnt == LAST);
endmodule

// File: rtl/rd_select.sv
// Chooses the byte returned on a read.
module rd_select import cbp_pkg::*; #(
  parameter int DW  = 8,
  parameter int NCH = 10
) (
  input  rd_sel_e         sel,
  input  logic [NCH-1:0]  ovf_flags,
  input  logic [DW-1:0]   gen_status,
  output logic [DW-1:0]   byte_out
);
  localparam int HI_BITS = NCH - DW;

  logic [DW-1:0] hi_byte;

  generate
    for (genvar i = 0; i < DW; i++) begin : g_hi
      if (i < HI_BITS) begin : g_flag
        assign hi_byte[i] = ovf_flags[DW+i];
      end else begin : g_pad
        assign hi_byte[i] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    unique case (sel)
      SEL_OVF_HI: byte_out = hi_byte;
      SEL_GEN:    byte_out = gen_status;
      default:    byte_out = ovf_flags[DW-1:0];
    endcase
  end
endmodule

// File: rtl/cpu_bus_port.sv
module cpu_bus_port import cbp_pkg::*; #(
  parameter int            DW          = 8,
  parameter int            NCH         = 10,
  parameter int            INIT_FRAMES = 2,
  parameter int            SYNC_STAGES = 2,
  parameter logic [DW-1:0] STATUS_OP   = 8'h06
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_sync,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          cd,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  input  logic [NCH-1:0] ovf_flags,
  input  logic [DW-1:0] gen_status,
  output logic [DW-1:0] opcode,
  output logic          opcode_stb,
  output logic [DW-1:0] operand,
  output logic          operand_stb
);
  logic wr_level, wr_evt, rd_level, rd_evt, ready;
  logic wr_take, rd_take;
  logic stat_mode_q, oe_q, op_stb_q, dat_stb_q;
  logic [DW-1:0] op_q, dat_q, dout_q, mux_byte;
  rd_sel_e sel;

  strobe_edge #(.STAGES(SYNC_STAGES), .RISE(1'b1)) u_wr (
    .clk(clk), .rst(rst), .strobe_n(wr_n), .level(wr_level), .evt(wr_evt));

  strobe_edge #(.STAGES(SYNC_STAGES), .RISE(1'b0)) u_rd (
    .clk(clk), .rst(rst), .strobe_n(rd_n), .level(rd_level), .evt(rd_evt));

  init_gate #(.FRAMES(INIT_FRAMES)) u_init (
    .clk(clk), .rst(rst), .frame_sync(frame_sync), .ready(ready));

  assign sel = stat_mode_q ? SEL_GEN : (cd ? SEL_OVF_HI : SEL_OVF_LO);

  rd_select #(.DW(DW), .NCH(NCH)) u_sel (
    .sel(sel), .ovf_flags(ovf_flags), .gen_status(gen_status), .byte_out(mux_byte));

  assign wr_take = wr_evt & ~cs_n & ready;
  assign rd_take = rd_evt & ~cs_n & ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q        <= '0;
      dat_q       <= '0;
      dout_q      <= '0;
      stat_mode_q <= 1'b0;
      oe_q        <= 1'b0;
      op_stb_q    <= 1'b0;
      dat_stb_q   <= 1'b0;
    end else begin
      op_stb_q  <= wr_take & cd;
      dat_stb_q <= wr_take & ~cd;
      if (wr_take && cd) begin
        op_q        <= bus_in;
        stat_mode_q <= (bus_in == STATUS_OP);
      end
      if (wr_take && !cd) dat_q <= bus_in;
      if (rd_take) dout_q <= mux_byte;
      oe_q <= ready & ~cs_n & ~rd_level & wr_level;
    end
  end

  assign bus_out     = dout_q;
  assign bus_oe      = oe_q;
  assign opcode      = op_q;
  assign opcode_stb  = op_stb_q;
  assign operand     = dat_q;
  assign operand_stb = dat_stb_q;
endmodule

// File: rtl/cpu_bus_port_chk.sv
module cpu_bus_port_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_n,
  input logic          ready,
  input logic          rd_evt,
  input logic          bus_oe,
  input logic [DW-1:0] bus_out,
  input logic [DW-1:0] opcode,
  input logic          opcode_stb,
  input logic [DW-1:0] operand,
  input logic          operand_stb
);
  assert_opcode_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !opcode_stb) |-> $stable(opcode));

  assert_operand_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !operand_stb) |-> $stable(operand));

  assert_single_kind_R2: assert property (@(posedge clk) disable iff (rst)
    !(opcode_stb && operand_stb));

  assert_hiz_cs_R6: assert property (@(posedge clk) disable iff (rst)
    $past(cs_n) |-> !bus_oe);

  assert_closed_init_R7: assert property (@(posedge clk) disable iff (rst)
    !ready |-> !bus_oe);

  assert_ignore_cs_R8: assert property (@(posedge clk) disable iff (rst)
    $past(cs_n) |-> (!opcode_stb && !operand_stb));

  assert_read_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rd_evt)) |-> $stable(bus_out));
endmodule

bind cpu_bus_port cpu_bus_port_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .ready(ready), .rd_evt(rd_evt),
  .bus_oe(bus_oe), .bus_out(bus_out), .opcode(opcode), .opcode_stb(opcode_stb),
  .operand(operand), .operand_stb(operand_stb));

// File: tb/sim_cpu_bus_port.sv
`timescale 1ns/1ps
module sim_cpu_bus_port;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_sync = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, cd = 1'b0;
  logic [7:0] bus_in = '0, gen_status = '0;
  logic [9:0] ovf_flags = '0;
  logic [7:0] bus_out, opcode, operand;
  logic bus_oe, opcode_stb, operand_stb;

  int n_chk = 0, n_fail = 0, n_op = 0, n_dat = 0;
  bit frame_en = 1'b0, done = 1'b0;

  always #2 clk = ~clk;

  cpu_bus_port u0 (
    .clk(clk), .rst(rst), .frame_sync(frame_sync), .cs_n(cs_n), .rd_n(rd_n),
    .wr_n(wr_n), .cd(cd), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .ovf_flags(ovf_flags), .gen_status(gen_status), .opcode(opcode),
    .opcode_stb(opcode_stb), .operand(operand), .operand_stb(operand_stb));

  initial begin
    int fc = 0;
    forever begin
      @(negedge clk);
      fc++;
      frame_sync = frame_en && (fc % 40 == 0);
    end
  end

  always @(negedge clk) begin
    if (opcode_stb)  n_op++;
    if (operand_stb) n_dat++;
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(bit c, logic [7:0] v, bit sel = 1'b1);
    @(negedge clk);
    cs_n = ~sel; cd = c; bus_in = v;
    tick(2); wr_n = 1'b0;
    tick(4); wr_n = 1'b1;
    tick(5); cs_n = 1'b1;
    tick(2);
  endtask

  task automatic bus_read(bit c, output logic [7:0] v, output logic oe, input bit sel = 1'b1);
    @(negedge clk);
    cs_n = ~sel; cd = c;
    tick(2); rd_n = 1'b0;
    tick(5); v = bus_out; oe = bus_oe;
    rd_n = 1'b1;
    tick(5); cs_n = 1'b1;
    tick(2);
  endtask

  task automatic wait_ready();
    frame_en = 1'b1;
    tick(100);
  endtask

  initial begin
    logic [7:0] v, keep;
    logic oe;
    int p_op, p_dat;
    tick(5);
    rst = 1'b0;
    tick(1);
    // R7: reset state
    chk("R7 opcode after reset", opcode, 0);
    chk("R7 operand after reset", operand, 0);
    chk("R7 bus_out after reset", bus_out, 0);
    chk("R7 oe after reset", bus_oe, 0);
    // R7: strobes ignored before initialization ends
    bus_write(1'b1, 8'h55);
    chk("R7 opcode before init", opcode, 0);
    ovf_flags = 10'h0AA;
    bus_read(1'b0, v, oe);
    chk("R7 oe before init", oe, 0);
    chk("R7 bus_out before init", v, 0);
    wait_ready();

    // R1/R2: exhaustive opcode and operand writes
    for (int i = 0; i < 256; i++) begin
      p_op = n_op; p_dat = n_dat;
      bus_write(1'b1, 8'(i));
      chk("R1 opcode value", opcode, i);
      chk("R1 one opcode pulse", n_op - p_op, 1);
      bus_write(1'b0, 8'(255 - i));
      chk("R2 operand value", operand, 255 - i);
      chk("R2 one operand pulse", n_dat - p_dat, 1);
      chk("R2 opcode untouched", opcode, i);
    end

    // R3/R4/R6: sweep all overflow patterns (mode off: last opcode 0xFF)
    for (int f = 0; f < 1024; f++) begin
      ovf_flags = 10'(f);
      bus_read(1'b0, v, oe);
      chk("R3 low byte", v, f & 8'hFF);
      chk("R6 oe during read", oe, 1);
      bus_read(1'b1, v, oe);
      chk("R4 high byte", v, f >> 8);
    end

    // R5: status mode
    ovf_flags = 10'h3C5;
    bus_write(1'b1, 8'h06);
    for (int g = 0; g < 16; g++) begin
      gen_status = 8'(g * 17 + 3);
      bus_read(1'b0, v, oe);
      chk("R5 status cd low", v, (g * 17 + 3) & 8'hFF);
      bus_read(1'b1, v, oe);
      chk("R5 status cd high", v, (g * 17 + 3) & 8'hFF);
    end
    bus_write(1'b0, 8'h33);
    bus_read(1'b0, v, oe);
    chk("R5 operand write keeps mode", v, gen_status);
    bus_write(1'b1, 8'h06);
    bus_read(1'b1, v, oe);
    chk("R5 repeated status opcode", v, gen_status);
    bus_write(1'b1, 8'h07);
    bus_read(1'b0, v, oe);
    chk("R5 other opcode leaves mode", v, 8'hC5);
    bus_read(1'b1, v, oe);
    chk("R5 other opcode high half", v, 8'h03);

    // R8/R6: strobes with chip select high
    keep = bus_out; p_op = n_op; p_dat = n_dat;
    bus_write(1'b1, 8'hA5, 1'b0);
    bus_write(1'b0, 8'h5A, 1'b0);
    chk("R8 opcode kept", opcode, 8'h07);
    chk("R8 operand kept", operand, 8'h33);
    chk("R8 no pulses", (n_op - p_op) + (n_dat - p_dat), 0);
    ovf_flags = 10'h011;
    bus_read(1'b0, v, oe, 1'b0);
    chk("R6 oe low with cs high", oe, 0);
    chk("R8 bus_out kept", v, keep);
    tick(3);
    chk("R9 bus_out held", bus_out, keep);

    // R7: reset in the middle of status mode
    bus_write(1'b1, 8'h06);
    bus_write(1'b0, 8'h77);
    @(negedge clk); rst = 1'b1;
    tick(3); rst = 1'b0; tick(1);
    chk("R7 opcode cleared", opcode, 0);
    chk("R7 operand cleared", operand, 0);
    chk("R7 bus_out cleared", bus_out, 0);
    tick(100);
    ovf_flags = 10'h2E4;
    gen_status = 8'h99;
    bus_read(1'b0, v, oe);
    chk("R7 mode cleared low", v, 8'hE4);
    bus_read(1'b1, v, oe);
    chk("R7 mode cleared high", v, 8'h02);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule